// File: doc/BRIEF.md
# Counter Line Increment and Repack Unit

This unit updates one 512-bit metadata line of an integrity structure. The line is divided into eight 64-bit slots. Each slot carries a 56-bit counter, one 7-bit piece of a 56-bit authentication tag, and one spare bit. A request gives the line, a 3-bit slot index and a freshly computed tag. The unit advances the counter in the selected slot by one step in the binary extension field GF(2^56), reduced by x^56 + x^55 + x^35 + x^34 + 1. It spreads the new tag across the slots and returns the rebuilt line.

Alongside the rebuilt line, the unit returns three further values. The first is the tag that was stored in the incoming line, reassembled from its eight pieces. The second is a copy of the rebuilt line with every non-counter bit cleared, ready for a tag hash. The third is a flag that is raised when the advanced counter has returned to its starting value of 1, which means the counter is exhausted. The line is still returned when that flag is raised. Tag computation is done outside this unit.

Control is a three-state machine with valid/ready handshakes on both sides. IDLE raises `in_ready`. An accepted request moves it IDLE→CALC. CALC always moves to HOLD on the next edge and registers all results. HOLD raises `out_valid` and moves HOLD→IDLE when `out_ready` is high. Otherwise it stays in HOLD.

Top module: `ctr_line_bump`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is accepted on a rising edge with `in_valid` and `in_ready` both high. On the next edge `in_ready` falls and stays low until the result is taken. `out_valid` rises on the second edge after the accepting edge.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and none of the result ports change.
- R4: The selected counter (bits [64i+55:64i] for index i) is shifted left by one. If its bit 55 was 1, the 56-bit shifted value is XORed with 0x80000C00000001.
- R5: The counters of the seven unselected slots appear unchanged in `out_line`.
- R6: Tag bits [7j+6:7j] of `in_tag` are placed at `out_line` bits [64j+62:64j+56], and bit 64j+63 of every slot is 0.
- R7: `out_old_tag` bits [7j+6:7j] equal bits [64j+62:64j+56] of the accepted `in_line`.
- R8: `out_hash_line` equals `out_line` with bits [64j+63:64j+56] of every slot forced to 0.
- R9: `out_exhausted` is 1 exactly when the advanced counter equals 1. A counter of 0xC0000600000000 gives 1 and raises the flag, and the rebuilt line is still delivered.
- R10: A selected counter of 0 stays 0 and does not raise `out_exhausted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_line | input | 512 | Metadata line to update |
| in_idx | input | 3 | Slot whose counter is advanced |
| in_tag | input | 56 | New tag to embed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_line | output | 512 | Rebuilt line |
| out_hash_line | output | 512 | Rebuilt line with only counter bits kept |
| out_old_tag | output | 56 | Tag that was stored in the accepted line |
| out_exhausted | output | 1 | Advanced counter wrapped to 1 |

## Verification
A wrong state transition shows up at the handshake pins. If the machine skips CALC, `out_valid` rises one edge early. If it leaves HOLD without `out_ready`, a result disappears. If it sticks, `in_ready` never returns. Each of these is visible within two edges of the request.

A wrong captured index or a missing reduction step shows only in the result fields of that same transaction. The bench compares every result field against a model on every transaction. The vectors include counters with bit 55 set, the counter that wraps to 1, a zero counter, and stalls on the output side.

// File: rtl/ctr_line_pkg.sv
package ctr_line_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } bump_state_e;

endpackage

// File: rtl/ctr_gf_step.sv
module ctr_gf_step #(
    parameter int CTR_W = 56,
    parameter logic [CTR_W-1:0] POLY = 56'h80_000C_0000_0001
) (
    input  logic [CTR_W-1:0] val_i,
    output logic [CTR_W-1:0] val_o
);
    logic [CTR_W-1:0] shifted;

    always_comb begin
        shifted = {val_i[CTR_W-2:0], 1'b0};
        if (val_i[CTR_W-1]) begin
            val_o = shifted ^ POLY;
        end else begin
            val_o = shifted;
        end
    end
endmodule

// File: rtl/ctr_line_unpack.sv
module ctr_line_unpack #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 64,
    parameter int CTR_W  = 56,
    parameter int TAG_W  = 56,
    localparam int LINE_W  = SLOTS * SLOT_W,
    localparam int IDX_W   = $clog2(SLOTS),
    localparam int CHUNK_W = TAG_W / SLOTS
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CTR_W-1:0]  sel_ctr_o,
    output logic [TAG_W-1:0]  tag_o
);
    logic [CTR_W-1:0] ctr_arr [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign ctr_arr[g] = line_i[g*SLOT_W +: CTR_W];
        assign tag_o[g*CHUNK_W +: CHUNK_W] = line_i[g*SLOT_W + CTR_W +: CHUNK_W];
    end

    assign sel_ctr_o = ctr_arr[idx_i];
endmodule

// File: rtl/ctr_line_repack.sv
module ctr_line_repack #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 64,
    parameter int CTR_W  = 56,
    parameter int TAG_W  = 56,
    localparam int LINE_W  = SLOTS * SLOT_W,
    localparam int IDX_W   = $clog2(SLOTS),
    localparam int CHUNK_W = TAG_W / SLOTS,
    localparam int SPARE_W = SLOT_W - CTR_W - CHUNK_W
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CTR_W-1:0]  new_ctr_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] hash_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [CTR_W-1:0] ctr_v;
        assign ctr_v = (idx_i == IDX_W'(g)) ? new_ctr_i : line_i[g*SLOT_W +: CTR_W];
        assign line_o[g*SLOT_W +: SLOT_W] =
            {{SPARE_W{1'b0}}, tag_i[g*CHUNK_W +: CHUNK_W], ctr_v};
        assign hash_o[g*SLOT_W +: SLOT_W] = {{(SLOT_W-CTR_W){1'b0}}, ctr_v};
    end
endmodule

// File: rtl/ctr_line_bump.sv
module ctr_line_bump
    import ctr_line_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 64,
    parameter int CTR_W  = 56,
    parameter int TAG_W  = 56,
    parameter logic [CTR_W-1:0] POLY = 56'h80_000C_0000_0001,
    localparam int LINE_W = SLOTS * SLOT_W,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LINE_W-1:0] out_line,
    output logic [LINE_W-1:0] out_hash_line,
    output logic [TAG_W-1:0]  out_old_tag,
    output logic              out_exhausted
);
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);

    bump_state_e state_q, state_d;

    logic [LINE_W-1:0] line_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;

    logic [CTR_W-1:0]  cur_ctr;
    logic [CTR_W-1:0]  nxt_ctr;
    logic [TAG_W-1:0]  stored_tag;
    logic [LINE_W-1:0] new_line;
    logic [LINE_W-1:0] new_hash;

    logic [LINE_W-1:0] res_line_q;
    logic [LINE_W-1:0] res_hash_q;
    logic [TAG_W-1:0]  res_tag_q;
    logic              res_exh_q;

    logic accept;

    ctr_line_unpack #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CTR_W(CTR_W), .TAG_W(TAG_W)
    ) u_unpack (
        .line_i   (line_q),
        .idx_i    (idx_q),
        .sel_ctr_o(cur_ctr),
        .tag_o    (stored_tag)
    );

    ctr_gf_step #(
        .CTR_W(CTR_W), .POLY(POLY)
    ) u_step (
        .val_i(cur_ctr),
        .val_o(nxt_ctr)
    );

    ctr_line_repack #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CTR_W(CTR_W), .TAG_W(TAG_W)
    ) u_repack (
        .line_i   (line_q),
        .idx_i    (idx_q),
        .new_ctr_i(nxt_ctr),
        .tag_i    (tag_q),
        .line_o   (new_line),
        .hash_o   (new_hash)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_CALC;
            ST_CALC: state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_CALC: ;
            ST_HOLD: out_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = in_valid && in_ready;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            idx_q  <= '0;
            tag_q  <= '0;
        end else if (accept) begin
            line_q <= in_line;
            idx_q  <= in_idx;
            tag_q  <= in_tag;
        end
    end

    // result registers, loaded while in CALC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_line_q <= '0;
            res_hash_q <= '0;
            res_tag_q  <= '0;
            res_exh_q  <= 1'b0;
        end else if (state_q == ST_CALC) begin
            res_line_q <= new_line;
            res_hash_q <= new_hash;
            res_tag_q  <= stored_tag;
            res_exh_q  <= (nxt_ctr == CTR_INIT);
        end
    end

    assign out_line      = res_line_q;
    assign out_hash_line = res_hash_q;
    assign out_old_tag   = res_tag_q;
    assign out_exhausted = res_exh_q;
endmodule

// File: rtl/ctr_line_bump_chk.sv
module ctr_line_bump_chk #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 64,
    parameter int CTR_W  = 56,
    parameter int TAG_W  = 56,
    parameter logic [CTR_W-1:0] POLY = 56'h80_000C_0000_0001,
    localparam int LINE_W = SLOTS * SLOT_W,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LINE_W-1:0] in_line,
    input logic [IDX_W-1:0]  in_idx,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LINE_W-1:0] out_line,
    input logic [LINE_W-1:0] out_hash_line,
    input logic              out_exhausted
);
    logic [LINE_W-1:0] ctr_mask;
    logic [LINE_W-1:0] top_mask;
    logic [LINE_W-1:0] keep_mask;
    logic [LINE_W-1:0] line_cap;
    logic [IDX_W-1:0]  idx_cap;
    logic [CTR_W-1:0]  cap_ctr;
    logic [CTR_W-1:0]  res_ctr;

    always_comb begin
        ctr_mask = '0;
        top_mask = '0;
        for (int s = 0; s < SLOTS; s++) begin
            ctr_mask[s*SLOT_W +: CTR_W] = '1;
            top_mask[s*SLOT_W + SLOT_W - 1] = 1'b1;
        end
        keep_mask = ctr_mask;
        keep_mask[idx_cap*SLOT_W +: CTR_W] = '0;
        cap_ctr = line_cap[idx_cap*SLOT_W +: CTR_W];
        res_ctr = out_line[idx_cap*SLOT_W +: CTR_W];
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            line_cap <= in_line;
            idx_cap  <= in_idx;
        end
    end

    // R2: handshake sides never overlap
    a_r2_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R2: result appears on the second edge after acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid) ##1 out_valid);

    // R3: stalled result holds
    a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_line) && $stable(out_hash_line)
             && $stable(out_exhausted)));

    // R4: selected counter advanced by one field step
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (res_ctr == (cap_ctr[CTR_W-1]
            ? ({cap_ctr[CTR_W-2:0], 1'b0} ^ POLY)
            : {cap_ctr[CTR_W-2:0], 1'b0})));

    // R5: other counters untouched
    a_r5_others: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_line & keep_mask) == (line_cap & keep_mask)));

    // R6: topmost bit of each slot is zero
    a_r6_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_line & top_mask) == '0));

    // R8: hash copy keeps only counters
    a_r8_hash_mask: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hash_line == (out_line & ctr_mask)));

    // R9: exhaustion flag matches a wrap to 1
    a_r9_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_exhausted == (res_ctr == CTR_W'(1))));
endmodule

bind ctr_line_bump ctr_line_bump_chk #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .CTR_W(CTR_W), .TAG_W(TAG_W), .POLY(POLY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_line      (in_line),
    .in_idx       (in_idx),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_line     (out_line),
    .out_hash_line(out_hash_line),
    .out_exhausted(out_exhausted)
);

// File: tb/ctr_line_bump_bench.sv
`timescale 1ns/1ps
module ctr_line_bump_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_line = '0;
    logic [2:0]   in_idx = '0;
    logic [55:0]  in_tag = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_line;
    logic [511:0] out_hash_line;
    logic [55:0]  out_old_tag;
    logic         out_exhausted;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ctr_line_bump u_ctr_line_bump (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_idx(in_idx), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_line(out_line), .out_hash_line(out_hash_line),
        .out_old_tag(out_old_tag), .out_exhausted(out_exhausted)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 200000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL R2 watchdog: cycles=%0d expected below 200000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [55:0] field_next(input logic [55:0] a);
        logic [55:0] r;
        r = a << 1;
        if (a[55]) r = r ^ 56'h80_000C_0000_0001;
        return r;
    endfunction

    task automatic chk_wide(input string req, input logic [511:0] act, input logic [511:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_tag(input string req, input logic [55:0] act, input logic [55:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] rnd_line();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic run_one(input logic [511:0] ln, input logic [2:0] ix,
                           input logic [55:0] tg, input int stall);
        logic [511:0] e_line, e_hash;
        logic [55:0]  e_old, c, n;
        logic         e_exh;
        e_line = '0;
        e_hash = '0;
        e_exh  = 1'b0;
        for (int s = 0; s < 8; s++) begin
            c = ln[s*64 +: 56];
            e_old[s*7 +: 7] = ln[s*64 + 56 +: 7];
            if (s == int'(ix)) begin
                n = field_next(c);
                e_exh = (n == 56'd1);
            end else begin
                n = c;
            end
            e_line[s*64 +: 64] = {1'b0, tg[s*7 +: 7], n};
            e_hash[s*64 +: 64] = {8'h00, n};
        end
        @(negedge clk);
        in_valid = 1'b1; in_line = ln; in_idx = ix; in_tag = tg;
        @(negedge clk);
        in_valid = 1'b0; in_line = rnd_line(); in_idx = ~ix;
        chk_bit("R2 ready low after accept", in_ready, 1'b0);
        chk_bit("R2 no early valid", out_valid, 1'b0);
        @(negedge clk);
        chk_bit("R2 valid on second edge", out_valid, 1'b1);
        for (int w = 0; w < stall; w++) begin
            @(negedge clk);
            chk_bit("R3 valid held in stall", out_valid, 1'b1);
            chk_wide("R3 line held in stall", out_line, e_line);
        end
        chk_wide("R4 R5 R6 rebuilt line", out_line, e_line);
        chk_wide("R8 hash copy", out_hash_line, e_hash);
        chk_tag("R7 old tag", out_old_tag, e_old);
        chk_bit("R9 R10 exhaustion flag", out_exhausted, e_exh);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk_bit("R2 valid drops after take", out_valid, 1'b0);
        chk_bit("R2 ready back after take", in_ready, 1'b1);
    endtask

    initial begin
        logic [511:0] ln;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk_bit("R1 reset ready", in_ready, 1'b1);
        chk_bit("R1 reset valid", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 idle valid", out_valid, 1'b0);

        // counter at initial value 1
        ln = rnd_line();
        ln[0 +: 56] = 56'd1;
        run_one(ln, 3'd0, 56'h12_3456_789A_BCDE, 0);
        // bit 55 set, reduction needed
        ln = rnd_line();
        ln[5*64 +: 56] = 56'hFF_FFFF_FFFF_FFFF;
        run_one(ln, 3'd5, 56'hFF_FFFF_FFFF_FFFF, 2);
        // R9: counter that wraps to 1
        ln = rnd_line();
        ln[7*64 +: 56] = 56'hC0_0006_0000_0000;
        run_one(ln, 3'd7, 56'h0, 1);
        // R10: zero counter
        ln = rnd_line();
        ln[3*64 +: 56] = 56'h0;
        run_one(ln, 3'd3, 56'hA5_A5A5_A5A5_A5A5, 0);
        // random traffic
        for (int t = 0; t < 40; t++) begin
            logic [55:0] tg;
            tg = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
            run_one(rnd_line(), 3'($urandom % 8), tg, int'($urandom % 4));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule